// File: doc/BRIEF.md
# DMA Transfer Bus-State Sequencer

This block steps each DMA transfer through its bus states and controls the upper half of the transfer address. The upper half is not driven on dedicated pins. It is placed on the data bus during an address-update state, and an external latch captures it on the falling edge of the address strobe. An address-enable output then gates the latched byte onto the address bus. The low address byte is driven on its own outputs for the whole service.

A transfer normally runs through an address state, a read-extension state and a read/write state. The address-update state comes first only when it is needed: at the first transfer of a service, or when the upper byte of the next address differs from the byte held in the external latch. A compressed-timing input removes the read-extension state, so a transfer can take two clocks.

The address source supplies on `nxt_addr_i` the address of the transfer about to begin. The sequencer samples it on the clock edge that starts that transfer. During the last state of each transfer, `more_i` says whether the service continues.

Top module: `dma_xfer_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the sequencer goes to idle (`state_o` = 0) and every strobe, enable and address output reads zero.
- R2: `go_i` high in idle moves the sequencer to the upper-address state (`state_o` = 1) on the next edge. This happens even when the new upper byte equals the byte already latched.
- R3: In the upper-address state, `hi_bus_o` carries bits 15:8 of the sampled address and `adr_stb_o` is high. `adr_stb_o` is low in every other state, so its falling edge coincides with entry to the address state (`state_o` = 2).
- R4: With `squeeze_i` low in the address state, the next states are the read-extension state (`state_o` = 3) and then the read/write state (`state_o` = 4).
- R5: With `squeeze_i` high in the address state, the next state is the read/write state, and the read-extension state is skipped.
- R6: `rd_o` is high in the read-extension and read/write states. `wr_o` is high only in the read/write state. In compressed timing both pulses therefore last one clock.
- R7: If `more_i` is high in the read/write state and bits 15:8 of `nxt_addr_i` equal the latched upper byte, the next state is the address state and no address strobe is produced.
- R8: If `more_i` is high in the read/write state and bits 15:8 of `nxt_addr_i` differ from the latched upper byte, the next state is the upper-address state. A sequential service therefore strobes once at its start and once for each carry or borrow across bit 8.
- R9: If `more_i` is low in the read/write state, the sequencer returns to idle and `adr_en_o` goes low. `adr_en_o` is high in every non-idle state.
- R10: `lo_adr_o` shows bits 7:0 of the sampled address while `adr_en_o` is high, and zero in idle. `hi_bus_o` is zero outside the upper-address state.
- R11: `go_i` is ignored in every state except idle.
- R12: `nxt_addr_i` is sampled only on the edge that begins a transfer. Changes to it at any other time do not alter `lo_adr_o` or `hi_bus_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| go_i | input | 1 | Start-of-service strobe, acted on in idle only |
| nxt_addr_i | input | 16 | Address of the transfer about to begin |
| squeeze_i | input | 1 | Compressed timing: skip the read-extension state |
| more_i | input | 1 | Service continues after the current transfer |
| state_o | output | 3 | Current state: 0 idle, 1 upper-address, 2 address, 3 read-extension, 4 read/write |
| adr_stb_o | output | 1 | Address strobe for the external upper-byte latch |
| adr_en_o | output | 1 | Enables the latched upper byte onto the address bus |
| lo_adr_o | output | 8 | Low address byte |
| hi_bus_o | output | 8 | Upper address byte driven on the data bus |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |

## Verification
Inputs sampled on a rising edge (`go_i`, `squeeze_i`, `more_i`, and `nxt_addr_i` at a transfer start) take effect in `state_o` one edge later. Every other output is decoded from the registered state and the registered address, so it changes in the same cycle as `state_o` with no further delay. The bench drives inputs on the falling edge and advances its reference state on the rising edge. It compares every output at the next falling edge, half a cycle after the edge that produced it. Outside the sampling points, `go_i` and `nxt_addr_i` are randomised at every falling edge, so any premature use of them shows up in that same comparison.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_HI   = 3'd1,
        ST_ADR  = 3'd2,
        ST_EXT  = 3'd3,
        ST_RW   = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic strobe;
        logic enable;
        logic rd;
        logic wr;
    } bus_ctl_t;

    typedef struct packed {
        logic go;
        logic squeeze;
        logic more;
        logic hi_change;
    } seq_in_t;

    function automatic seq_state_e next_state(input seq_state_e cur, input seq_in_t in);
        seq_state_e nxt;
        nxt = cur;
        case (cur)
            ST_IDLE: nxt = in.go ? ST_HI : ST_IDLE;
            ST_HI:   nxt = ST_ADR;
            ST_ADR:  nxt = in.squeeze ? ST_RW : ST_EXT;
            ST_EXT:  nxt = ST_RW;
            ST_RW: begin
                if (!in.more)          nxt = ST_IDLE;
                else if (in.hi_change) nxt = ST_HI;
                else                   nxt = ST_ADR;
            end
            default: nxt = ST_IDLE;
        endcase
        return nxt;
    endfunction

    function automatic logic starts_transfer(input seq_state_e cur, input seq_in_t in);
        return ((cur == ST_IDLE) && in.go) || ((cur == ST_RW) && in.more);
    endfunction

    function automatic bus_ctl_t ctl_for(input seq_state_e s);
        bus_ctl_t c;
        c.strobe = (s == ST_HI);
        c.enable = (s != ST_IDLE);
        c.rd     = (s == ST_EXT) || (s == ST_RW);
        c.wr     = (s == ST_RW);
        return c;
    endfunction

endpackage

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
    import dma_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  seq_in_t    in,
    output seq_state_e state,
    output logic       load_addr,
    output logic       capture_hi
);

    seq_state_e state_q;
    seq_state_e state_d;

    always_comb begin
        state_d = next_state(state_q, in);
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign state      = state_q;
    assign load_addr  = starts_transfer(state_q, in);
    assign capture_hi = (state_q == ST_HI);

    assert_go_enters_hi_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && in.go) |=> (state_q == ST_HI));

    assert_hi_then_adr_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HI) |=> (state_q == ST_ADR));

    assert_normal_extends_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ADR && !in.squeeze) |=> (state_q == ST_EXT));

    assert_squeeze_skips_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ADR && in.squeeze) |=> (state_q == ST_RW));

    assert_same_hi_no_strobe_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RW && in.more && !in.hi_change) |=> (state_q == ST_ADR));

    assert_new_hi_strobes_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RW && in.more && in.hi_change) |=> (state_q == ST_HI));

    assert_end_to_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RW && !in.more) |=> (state_q == ST_IDLE));

    assert_go_ignored_busy_R11: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE && state_q != ST_RW) |=> (state_q != ST_IDLE));

endmodule

// File: rtl/dma_seq_addr.sv
module dma_seq_addr #(
    parameter int ADDR_W = 16,
    parameter int LO_W   = 8,
    localparam int HI_W  = ADDR_W - LO_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] nxt_addr,
    input  logic              load_addr,
    input  logic              capture_hi,
    output logic [ADDR_W-1:0] addr_q,
    output logic [HI_W-1:0]   latched_hi,
    output logic              hi_change
);

    logic [ADDR_W-1:0] addr_r;
    logic [HI_W-1:0]   hi_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_r <= '0;
            hi_r   <= '0;
        end else begin
            if (load_addr)  addr_r <= nxt_addr;
            if (capture_hi) hi_r   <= addr_r[ADDR_W-1:LO_W];
        end
    end

    assign addr_q     = addr_r;
    assign latched_hi = hi_r;
    assign hi_change  = (nxt_addr[ADDR_W-1:LO_W] != hi_r);

    assert_addr_held_R12: assert property (@(posedge clk) disable iff (rst)
        (!load_addr) |=> $stable(addr_r));

endmodule

// File: rtl/dma_seq_bus.sv
module dma_seq_bus
    import dma_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LO_W   = 8,
    localparam int HI_W  = ADDR_W - LO_W
) (
    input  logic              clk,
    input  logic              rst,
    input  seq_state_e        state,
    input  logic [ADDR_W-1:0] addr_q,
    output logic              adr_stb,
    output logic              adr_en,
    output logic [LO_W-1:0]   lo_adr,
    output logic [HI_W-1:0]   hi_bus,
    output logic              rd,
    output logic              wr
);

    bus_ctl_t ctl;

    always_comb begin
        ctl     = ctl_for(state);
        adr_stb = ctl.strobe;
        adr_en  = ctl.enable;
        rd      = ctl.rd;
        wr      = ctl.wr;
        lo_adr  = ctl.enable ? addr_q[LO_W-1:0] : '0;
        hi_bus  = ctl.strobe ? addr_q[ADDR_W-1:LO_W] : '0;
    end

    assert_strobe_falls_into_adr_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(adr_stb) |-> (state == ST_ADR));

    assert_write_within_read_R6: assert property (@(posedge clk) disable iff (rst)
        wr |-> rd);

    assert_read_needs_enable_R9: assert property (@(posedge clk) disable iff (rst)
        rd |-> adr_en);

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !adr_en |-> (lo_adr == '0 && hi_bus == '0));

endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
    import dma_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LO_W   = 8,
    localparam int HI_W  = ADDR_W - LO_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go_i,
    input  logic [ADDR_W-1:0] nxt_addr_i,
    input  logic              squeeze_i,
    input  logic              more_i,
    output logic [2:0]        state_o,
    output logic              adr_stb_o,
    output logic              adr_en_o,
    output logic [LO_W-1:0]   lo_adr_o,
    output logic [HI_W-1:0]   hi_bus_o,
    output logic              rd_o,
    output logic              wr_o
);

    seq_in_t           seq_in;
    seq_state_e        state;
    logic              load_addr;
    logic              capture_hi;
    logic [ADDR_W-1:0] addr_q;
    logic [HI_W-1:0]   latched_hi;
    logic              hi_change;

    always_comb begin
        seq_in.go        = go_i;
        seq_in.squeeze   = squeeze_i;
        seq_in.more      = more_i;
        seq_in.hi_change = hi_change;
    end

    dma_seq_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .in         (seq_in),
        .state      (state),
        .load_addr  (load_addr),
        .capture_hi (capture_hi)
    );

    dma_seq_addr #(.ADDR_W(ADDR_W), .LO_W(LO_W)) u_addr (
        .clk        (clk),
        .rst        (rst),
        .nxt_addr   (nxt_addr_i),
        .load_addr  (load_addr),
        .capture_hi (capture_hi),
        .addr_q     (addr_q),
        .latched_hi (latched_hi),
        .hi_change  (hi_change)
    );

    dma_seq_bus #(.ADDR_W(ADDR_W), .LO_W(LO_W)) u_bus (
        .clk     (clk),
        .rst     (rst),
        .state   (state),
        .addr_q  (addr_q),
        .adr_stb (adr_stb_o),
        .adr_en  (adr_en_o),
        .lo_adr  (lo_adr_o),
        .hi_bus  (hi_bus_o),
        .rd      (rd_o),
        .wr      (wr_o)
    );

    assign state_o = state;

    assert_latch_tracks_strobe_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(adr_stb_o) |-> (latched_hi == addr_q[ADDR_W-1:LO_W]));

endmodule

// File: tb/dma_xfer_seq_bench.sv
module dma_xfer_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        go_i = 1'b0;
    logic [15:0] nxt_addr_i = '0;
    logic        squeeze_i = 1'b0;
    logic        more_i = 1'b0;
    logic [2:0]  state_o;
    logic        adr_stb_o, adr_en_o, rd_o, wr_o;
    logic [7:0]  lo_adr_o, hi_bus_o;

    int n_vec = 0;
    int n_bad = 0;
    int cycles = 0;
    bit wd = 1'b0;

    // reference model: state codes 0 idle, 1 upper-address, 2 address, 3 extension, 4 read/write
    logic [2:0]  m_state = 3'd0;
    logic [15:0] m_addr = '0;
    logic [7:0]  m_hi = '0;
    string       m_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_xfer_seq u_dma_xfer_seq (
        .clk(clk), .rst(rst), .go_i(go_i), .nxt_addr_i(nxt_addr_i),
        .squeeze_i(squeeze_i), .more_i(more_i), .state_o(state_o),
        .adr_stb_o(adr_stb_o), .adr_en_o(adr_en_o), .lo_adr_o(lo_adr_o),
        .hi_bus_o(hi_bus_o), .rd_o(rd_o), .wr_o(wr_o)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_state <= 3'd0; m_addr <= '0; m_hi <= '0; m_tag <= "R1";
        end else begin
            case (m_state)
                3'd0: if (go_i) begin
                          m_state <= 3'd1; m_addr <= nxt_addr_i; m_tag <= "R2";
                      end else m_tag <= "R9";
                3'd1: begin m_state <= 3'd2; m_hi <= m_addr[15:8]; m_tag <= go_i ? "R3,R11" : "R3"; end
                3'd2: begin
                          m_state <= squeeze_i ? 3'd4 : 3'd3;
                          m_tag <= squeeze_i ? "R5,R11" : "R4,R11";
                      end
                3'd3: begin m_state <= 3'd4; m_tag <= "R4,R11"; end
                default: begin
                    if (!more_i) begin m_state <= 3'd0; m_tag <= "R9"; end
                    else begin
                        m_addr <= nxt_addr_i;
                        if (nxt_addr_i[15:8] != m_hi) begin m_state <= 3'd1; m_tag <= "R8"; end
                        else begin m_state <= 3'd2; m_tag <= "R7"; end
                    end
                end
            endcase
        end
    end

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag, input string what);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, what, act, exp, cycles);
        end
    endtask

    task automatic tick();
        logic [2:0] es;
        @(negedge clk);
        cycles++;
        if (cycles > WD_LIMIT && !wd) begin
            wd = 1'b1; n_bad++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, WD_LIMIT);
        end
        es = m_state;
        chk(16'(state_o),   16'(es), m_tag, "state");
        chk(16'(adr_stb_o), 16'(es == 3'd1), "R3", "adr_stb");
        chk(16'(adr_en_o),  16'(es != 3'd0), "R9", "adr_en");
        chk(16'(lo_adr_o),  (es != 3'd0) ? 16'(m_addr[7:0]) : 16'h0, "R10,R12", "lo_adr");
        chk(16'(hi_bus_o),  (es == 3'd1) ? 16'(m_addr[15:8]) : 16'h0, "R3,R10", "hi_bus");
        chk(16'(rd_o),      16'(es == 3'd3 || es == 3'd4), "R6", "rd");
        chk(16'(wr_o),      16'(es == 3'd4), "R6", "wr");
    endtask

    function automatic logic pick_sq(input int cmode);
        if (cmode == 0) return 1'b0;
        if (cmode == 1) return 1'b1;
        return 1'($urandom % 2);
    endfunction

    // one service of n transfers starting at a0, address stepping by step
    task automatic service(input logic [15:0] a0, input int n, input int step, input int cmode);
        logic [15:0] cur;
        int done = 0;
        int stbs = 0;
        int exp_stb = 1;
        cur = a0;
        go_i = 1'b1; nxt_addr_i = a0; squeeze_i = pick_sq(cmode); more_i = 1'($urandom % 2);
        forever begin
            tick();
            if (wd || m_state == 3'd0) break;
            if (adr_stb_o) stbs++;
            go_i = 1'($urandom % 2);
            nxt_addr_i = 16'($urandom);
            more_i = 1'($urandom % 2);
            squeeze_i = (m_state == 3'd2) ? pick_sq(cmode) : 1'($urandom % 2);
            if (m_state == 3'd4) begin
                done++;
                if (done < n) begin
                    logic [15:0] nx;
                    nx = 16'(int'(cur) + step);
                    if (nx[15:8] != cur[15:8]) exp_stb++;
                    cur = nx; nxt_addr_i = nx; more_i = 1'b1;
                end else more_i = 1'b0;
            end
        end
        go_i = 1'b0;
        chk(16'(stbs), 16'(exp_stb), "R8", "strobes per service");
    endtask

    task automatic idle_gap(input int k);
        for (int i = 0; i < k; i++) begin
            go_i = 1'b0; nxt_addr_i = 16'($urandom); more_i = 1'($urandom % 2);
            tick();
        end
    endtask

    initial begin
        // R1: reset state
        rst = 1'b1;
        for (int i = 0; i < 3; i++) tick();
        rst = 1'b0;
        idle_gap(2);
        // carry across bit 8 in normal timing: strobes at 12FE and 1300
        if (!wd) service(16'h12FE, 4, 1, 0);
        idle_gap(2);
        // R2: same upper byte as latched still strobes at the first transfer
        if (!wd) service(16'h1305, 2, 1, 1);
        idle_gap(1);
        // long compressed run: one strobe per 256 transfers plus the first
        if (!wd) service(16'h40F0, 520, 1, 1);
        idle_gap(1);
        // borrow across bit 8 going down
        if (!wd) service(16'h2105, 300, -1, 0);
        // wrap at the top of the address space
        if (!wd) service(16'hFFFE, 4, 1, 2);
        idle_gap(3);
        // single-transfer services, both timings
        if (!wd) service(16'h00FF, 1, 1, 0);
        if (!wd) service(16'h00FF, 1, 1, 1);
        // constrained random services
        void'($urandom(32'd1234));
        for (int s = 0; s < 250 && !wd; s++) begin
            int stp;
            case ($urandom % 4)
                0: stp = 1;
                1: stp = -1;
                2: stp = 256;
                default: stp = -256;
            endcase
            service(16'($urandom), 1 + int'($urandom % 12), stp, 2);
            idle_gap(int'($urandom % 3));
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule